// File: doc/BRIEF.md
# Error Status and Header Logging Unit

This block is the error logging unit of a single function. Error detectors elsewhere in the function pulse one strobe per error type for one cycle. There are twelve uncorrectable types and six correctable types. Each uncorrectable pulse comes with the four-dword header of the packet that caused it. The unit keeps the status, mask and severity state, and holds the headers of unmasked uncorrectable errors in a small queue. The oldest queued entry is shown through a first-error pointer and a four-dword header log.

For every cycle that carries events, the unit decides which error message class to request. The classes are correctable, non-fatal and fatal. Device-level class enables gate the request, and device-level class status bits record every class that occurred. Software reads and writes the state through a word-wide register port.

With multiple-header recording enabled, clearing the status bit that the pointer selects moves the pointer and the log to the next queued error. If an error arrives while the queue is full, its header is dropped and a correctable overflow error is raised.

Register map, selected by the 4-bit address:

| Address | Contents |
|---|---|
| 0 | uncorrectable status (write 1 to clear) |
| 1 | uncorrectable mask |
| 2 | uncorrectable severity |
| 3 | correctable status (write 1 to clear) |
| 4 | correctable mask |
| 5 | control: bit0 multiple-header enable, bit1 correctable enable, bit2 non-fatal enable, bit3 fatal enable |
| 6 | device class status (write 1 to clear): bit0 correctable, bit1 non-fatal, bit2 fatal |
| 7 | first-error pointer (read only) |
| 8 to 11 | header log dwords 0 to 3 (read only) |

All registers reset to zero.

Top module: `aer_log_top`

## Requirements
- R1: A pulse on `ue_evt[i]` sets uncorrectable status bit i (address 0) on the next edge, whether or not bit i is masked. Writing 1 to a bit of address 0 clears it, and a set in the same cycle wins over the clear.
- R2: A pulse on `ce_evt[j]` sets correctable status bit j (address 3) on the next edge. Writing 1 to a bit of address 3 clears it.
- R3: An uncorrectable error whose mask bit (address 1) is set causes no message request and puts no header into the queue.
- R4: `msg_req` pulses for exactly one cycle, on the cycle after the event. `msg_cls` reads 3 for a fatal request, 2 for non-fatal and 1 for correctable. An unmasked uncorrectable error is fatal when its severity bit (address 2) is 1 and non-fatal when it is 0.
- R5: Address 7 reads the bit index of the oldest queued error, and addresses 8 to 11 read its header dwords 0 to 3. Dword 0 is `ue_hdr[31:0]`. All of these read 0 when the queue is empty.
- R6: When several unmasked uncorrectable errors arrive in one cycle, only the lowest bit index is queued, with that cycle's header.
- R7: With multiple-header recording enabled, a write to address 0 that clears the status bit the pointer selects removes that entry, and the pointer and log move to the next entry. Clearing any other bit leaves the pointer unchanged.
- R8: With multiple-header recording enabled, the queue holds QDEPTH entries. An unmasked uncorrectable error that arrives while the queue is full is not queued. It sets correctable status bit 4 (header overflow), and that bit counts as a correctable error.
- R9: With multiple-header recording disabled, one entry is held until its pointed status bit is cleared. Later errors are not queued and do not raise overflow.
- R10: When `ue_advisory` is high in a cycle with an unmasked non-fatal uncorrectable error, correctable status bit 5 is set and the error is reported as correctable instead of non-fatal. Fatal errors in that cycle are unaffected.
- R11: A class is requested only when its enable bit in address 5 is set. Address 6 records every class that occurred, whether or not it was enabled, and its bits are cleared by writing 1.
- R12: When several enabled classes occur in one cycle, only one request is made, in the priority fatal, then non-fatal, then correctable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ue_evt | input | 12 | uncorrectable error strobes |
| ue_advisory | input | 1 | marks this cycle's non-fatal errors as advisory |
| ce_evt | input | 6 | correctable error strobes |
| ue_hdr | input | 128 | captured packet header for this cycle's uncorrectable error |
| reg_addr | input | 4 | register address |
| reg_wr | input | 1 | register write strobe |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| msg_req | output | 1 | one-cycle error message request |
| msg_cls | output | 2 | class of the request: 1 correctable, 2 non-fatal, 3 fatal |

## Verification
The bench builds the unit with QDEPTH set to 3 and multiple-header recording available, while keeping the default widths of 12 and 6. The shallow queue lets the overflow path be reached after three logged errors. It also lets the queue be drained back to empty within a single short scenario. The one-entry mode is reached by clearing the control bit, so both capacity limits are exercised in the same build.

// File: rtl/aer_pkg.sv
package aer_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_COR  = 2'd1,
    CLS_NF   = 2'd2,
    CLS_FAT  = 2'd3
  } msg_cls_e;

  localparam logic [3:0] A_UE_STAT = 4'd0;
  localparam logic [3:0] A_UE_MASK = 4'd1;
  localparam logic [3:0] A_UE_SEV  = 4'd2;
  localparam logic [3:0] A_CE_STAT = 4'd3;
  localparam logic [3:0] A_CE_MASK = 4'd4;
  localparam logic [3:0] A_CTRL    = 4'd5;
  localparam logic [3:0] A_DEV     = 4'd6;
  localparam logic [3:0] A_FEP     = 4'd7;
  localparam logic [3:0] A_HDR0    = 4'd8;

  // {found, index} of the lowest set bit
  function automatic logic [5:0] lowest_idx(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = {1'b1, 5'(k)};
    end
    return r;
  endfunction

  function automatic msg_cls_e pick_cls(input logic fat, input logic nf, input logic cor);
    if (fat)      return CLS_FAT;
    else if (nf)  return CLS_NF;
    else if (cor) return CLS_COR;
    else          return CLS_NONE;
  endfunction

endpackage

// File: rtl/aer_hdr_queue.sv
module aer_hdr_queue #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 5,
  parameter int HDR_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic [HDR_W-1:0] push_hdr,
  input  logic             pop,
  input  logic             multi_en,
  output logic             full,
  output logic             empty,
  output logic [IDX_W-1:0] head_idx,
  output logic [HDR_W-1:0] head_hdr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] idx_mem [DEPTH];
  logic [HDR_W-1:0] hdr_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, limit;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign limit   = multi_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full    = (count >= limit);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      idx_mem[wr_ptr] <= push_idx;
      hdr_mem[wr_ptr] <= push_hdr;
    end
  end

  assign head_idx = empty ? '0 : idx_mem[rd_ptr];
  assign head_hdr = empty ? '0 : hdr_mem[rd_ptr];

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R9
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi_en && !empty && !pop) |=> (count == $past(count)) || $past(multi_en) != multi_en);

endmodule

// File: rtl/aer_msg_arb.sv
module aer_msg_arb
  import aer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fat_hit,
  input  logic       nf_hit,
  input  logic       cor_hit,
  input  logic       en_fat,
  input  logic       en_nf,
  input  logic       en_cor,
  output logic       msg_req,
  output logic [1:0] msg_cls
);
  logic     send_fat, send_nf, send_cor;
  msg_cls_e cls_next;

  assign send_fat = fat_hit && en_fat;
  assign send_nf  = nf_hit && en_nf;
  assign send_cor = cor_hit && en_cor;
  assign cls_next = pick_cls(send_fat, send_nf, send_cor);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_req <= 1'b0;
      msg_cls <= CLS_NONE;
    end else begin
      msg_req <= (cls_next != CLS_NONE);
      msg_cls <= cls_next;
    end
  end

  // R12
  fatal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_fat |=> (msg_req && msg_cls == CLS_FAT));

  // R4
  req_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (msg_cls != CLS_NONE));

  // R11
  gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_fat && !send_nf && !send_cor) |=> !msg_req);

endmodule

// File: rtl/aer_log_top.sv
module aer_log_top
  import aer_pkg::*;
#(
  parameter int UE_W    = 12,
  parameter int CE_W    = 6,
  parameter int QDEPTH  = 4,
  parameter int MHR_CAP = 1,
  parameter int DW      = 32,
  parameter int HDR_DW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [UE_W-1:0]      ue_evt,
  input  logic                 ue_advisory,
  input  logic [CE_W-1:0]      ce_evt,
  input  logic [DW*HDR_DW-1:0] ue_hdr,
  input  logic [3:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 msg_req,
  output logic [1:0]           msg_cls
);
  localparam int HDR_W  = DW * HDR_DW;
  localparam int IDX_W  = 5;
  localparam int CE_OVF = CE_W - 2;
  localparam int CE_ADV = CE_W - 1;

  logic [UE_W-1:0] ue_stat, ue_mask, ue_sev;
  logic [CE_W-1:0] ce_stat, ce_mask;
  logic [3:0]      ctrl_q;
  logic [2:0]      dev_stat;
  logic            mhr_en;

  // named internal events
  logic [UE_W-1:0]  ue_live, ue_fat, ue_nonfat;
  logic             adv_hit, fat_hit, nf_hit, cor_hit;
  logic [5:0]       log_pick;
  logic             push_req, pop_req, ovf_evt;
  logic [CE_W-1:0]  ce_new, ce_live;
  logic             q_full, q_empty;
  logic [IDX_W-1:0] head_idx;
  logic [HDR_W-1:0] head_hdr;
  logic [DW-1:0]    stat_ext;
  logic             wr_ue_stat, wr_ce_stat, wr_dev;

  generate
    if (MHR_CAP != 0) begin : g_mhr
      assign mhr_en = ctrl_q[0];
    end else begin : g_nomhr
      assign mhr_en = 1'b0;
    end
  endgenerate

  assign ue_live   = ue_evt & ~ue_mask;
  assign ue_fat    = ue_live & ue_sev;
  assign ue_nonfat = ue_live & ~ue_sev;
  assign adv_hit   = ue_advisory && (|ue_nonfat);
  assign log_pick  = lowest_idx(32'(ue_live));
  assign push_req  = log_pick[5];
  assign ovf_evt   = push_req && q_full && mhr_en;

  always_comb begin
    ce_new         = ce_evt;
    ce_new[CE_OVF] = ce_evt[CE_OVF] | ovf_evt;
    ce_new[CE_ADV] = ce_evt[CE_ADV] | adv_hit;
  end
  assign ce_live = ce_new & ~ce_mask;

  assign fat_hit = |ue_fat;
  assign nf_hit  = (|ue_nonfat) && !ue_advisory;
  assign cor_hit = |ce_live;

  assign wr_ue_stat = reg_wr && (reg_addr == A_UE_STAT);
  assign wr_ce_stat = reg_wr && (reg_addr == A_CE_STAT);
  assign wr_dev     = reg_wr && (reg_addr == A_DEV);
  assign stat_ext   = DW'(ue_stat);
  assign pop_req    = wr_ue_stat && !q_empty && reg_wdata[head_idx] && stat_ext[head_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ue_stat  <= '0;
      ue_mask  <= '0;
      ue_sev   <= '0;
      ce_stat  <= '0;
      ce_mask  <= '0;
      ctrl_q   <= '0;
      dev_stat <= '0;
    end else begin
      ue_stat  <= (ue_stat & ~(wr_ue_stat ? reg_wdata[UE_W-1:0] : '0)) | ue_evt;
      ce_stat  <= (ce_stat & ~(wr_ce_stat ? reg_wdata[CE_W-1:0] : '0)) | ce_new;
      dev_stat <= (dev_stat & ~(wr_dev ? reg_wdata[2:0] : 3'b0)) | {fat_hit, nf_hit, cor_hit};
      if (reg_wr && reg_addr == A_UE_MASK) ue_mask <= reg_wdata[UE_W-1:0];
      if (reg_wr && reg_addr == A_UE_SEV)  ue_sev  <= reg_wdata[UE_W-1:0];
      if (reg_wr && reg_addr == A_CE_MASK) ce_mask <= reg_wdata[CE_W-1:0];
      if (reg_wr && reg_addr == A_CTRL)    ctrl_q  <= reg_wdata[3:0];
    end
  end

  aer_hdr_queue #(.DEPTH(QDEPTH), .IDX_W(IDX_W), .HDR_W(HDR_W)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_req),
    .push_idx (log_pick[4:0]),
    .push_hdr (ue_hdr),
    .pop      (pop_req),
    .multi_en (mhr_en),
    .full     (q_full),
    .empty    (q_empty),
    .head_idx (head_idx),
    .head_hdr (head_hdr)
  );

  aer_msg_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .fat_hit (fat_hit),
    .nf_hit  (nf_hit),
    .cor_hit (cor_hit),
    .en_fat  (ctrl_q[3]),
    .en_nf   (ctrl_q[2]),
    .en_cor  (ctrl_q[1]),
    .msg_req (msg_req),
    .msg_cls (msg_cls)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_UE_STAT: reg_rdata = DW'(ue_stat);
      A_UE_MASK: reg_rdata = DW'(ue_mask);
      A_UE_SEV:  reg_rdata = DW'(ue_sev);
      A_CE_STAT: reg_rdata = DW'(ce_stat);
      A_CE_MASK: reg_rdata = DW'(ce_mask);
      A_CTRL:    reg_rdata = DW'(ctrl_q);
      A_DEV:     reg_rdata = DW'(dev_stat);
      A_FEP:     reg_rdata = DW'(head_idx);
      default: begin
        for (int k = 0; k < HDR_DW; k++) begin
          if (reg_addr == A_HDR0 + 4'(k)) reg_rdata = head_hdr[k*DW +: DW];
        end
      end
    endcase
  end

  // R1
  ue_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ue_evt) |=> ((ue_stat & $past(ue_evt)) == $past(ue_evt)));

  // R3
  masked_nolog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_live == '0 && !pop_req) |=> ($stable(head_idx) && $stable(q_empty)));

  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ce_stat[CE_OVF]);

  // R10
  adv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_hit |=> ce_stat[CE_ADV]);

endmodule

// File: tb/aer_log_top_tb_top.sv
module aer_log_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [11:0]  ue_evt;
  logic         ue_advisory;
  logic [5:0]   ce_evt;
  logic [127:0] ue_hdr;
  logic [3:0]   reg_addr;
  logic         reg_wr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         msg_req;
  logic [1:0]   msg_cls;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aer_log_top #(.QDEPTH(3), .MHR_CAP(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ue_evt(ue_evt), .ue_advisory(ue_advisory),
    .ce_evt(ce_evt), .ue_hdr(ue_hdr), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_req(msg_req), .msg_cls(msg_cls)
  );

  function automatic logic [127:0] mk_hdr(input logic [31:0] s);
    return {s + 32'd3, s + 32'd2, s + 32'd1, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ue_evt = '0; ue_advisory = 1'b0; ce_evt = '0; ue_hdr = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // drive one cycle of events; returns at the negedge where msg_req is visible
  task automatic evt(input logic [11:0] u, input logic [5:0] c, input logic adv, input logic [127:0] h);
    @(negedge clk);
    ue_evt = u; ce_evt = c; ue_advisory = adv; ue_hdr = h;
    @(negedge clk);
    ue_evt = '0; ce_evt = '0; ue_advisory = 1'b0; ue_hdr = '0;
  endtask

  task automatic chk_msg(input string req, input logic req_exp, input logic [1:0] cls_exp);
    chk(req, {31'd0, msg_req}, {31'd0, req_exp});
    if (req_exp) chk(req, {30'd0, msg_cls}, {30'd0, cls_exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R4 reset msg_req", {31'd0, msg_req}, 32'd0);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      chk("R5 reset regs", d, 32'd0);
    end
  endtask

  task automatic t_basic();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hF);
    evt(12'h008, 6'd0, 1'b0, mk_hdr(32'hA000));
    chk_msg("R4 nonfatal", 1'b1, 2'd2);
    @(negedge clk);
    chk_msg("R4 one-cycle pulse", 1'b0, 2'd0);
    rd(4'd0, d); chk("R1 status set", d, 32'h008);
    rd(4'd6, d); chk("R11 dev nf", d, 32'h2);
    rd(4'd7, d); chk("R5 pointer", d, 32'd3);
    rd(4'd8, d); chk("R5 hdr dw0", d, 32'hA000);
    rd(4'd11, d); chk("R5 hdr dw3", d, 32'hA003);
    wr(4'd0, 32'h008);
    rd(4'd0, d); chk("R1 w1c", d, 32'h0);
    rd(4'd7, d); chk("R7 popped to empty", d, 32'd0);
    rd(4'd8, d); chk("R5 empty hdr", d, 32'd0);
    // set wins over clear in same cycle
    @(negedge clk);
    ue_evt = 12'h010; reg_addr = 4'd0; reg_wdata = 32'h010; reg_wr = 1'b1;
    @(negedge clk);
    ue_evt = '0; reg_wr = 1'b0;
    rd(4'd0, d); chk("R1 set beats clear", d, 32'h010);
  endtask

  task automatic t_sev();
    do_reset();
    wr(4'd5, 32'hF);
    wr(4'd2, 32'h020);
    evt(12'h020, 6'd0, 1'b0, mk_hdr(32'h1));
    chk_msg("R4 fatal", 1'b1, 2'd3);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hF);
    wr(4'd1, 32'h080);
    evt(12'h080, 6'd0, 1'b0, mk_hdr(32'h2));
    chk_msg("R3 masked no msg", 1'b0, 2'd0);
    rd(4'd0, d); chk("R1 masked status set", d, 32'h080);
    rd(4'd8, d); chk("R3 masked not logged", d, 32'd0);
  endtask

  task automatic t_ce();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hF);
    evt(12'h0, 6'h02, 1'b0, '0);
    chk_msg("R2 cor msg", 1'b1, 2'd1);
    rd(4'd3, d); chk("R2 ce status", d, 32'h02);
    wr(4'd3, 32'h02);
    rd(4'd3, d); chk("R2 ce w1c", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'h1);
    evt(12'h0, 6'h01, 1'b0, '0);
    chk_msg("R11 disabled no msg", 1'b0, 2'd0);
    rd(4'd6, d); chk("R11 dev cor recorded", d, 32'h1);
    wr(4'd6, 32'h1);
    rd(4'd6, d); chk("R11 dev w1c", d, 32'h0);
  endtask

  task automatic t_prio();
    do_reset();
    wr(4'd5, 32'hF);
    wr(4'd2, 32'h020);
    evt(12'h021, 6'h01, 1'b0, mk_hdr(32'h3));
    chk_msg("R12 fatal wins", 1'b1, 2'd3);
    evt(12'h001, 6'h01, 1'b0, mk_hdr(32'h4));
    chk_msg("R12 nf over cor", 1'b1, 2'd2);
    wr(4'd5, 32'hB);
    evt(12'h001, 6'h01, 1'b0, mk_hdr(32'h5));
    chk_msg("R12 nf disabled falls to cor", 1'b1, 2'd1);
  endtask

  task automatic t_order();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hF);
    evt(12'h204, 6'd0, 1'b0, mk_hdr(32'hA0));
    evt(12'h040, 6'd0, 1'b0, mk_hdr(32'hB0));
    evt(12'h400, 6'd0, 1'b0, mk_hdr(32'hC0));
    rd(4'd7, d); chk("R6 lowest logged", d, 32'd2);
    rd(4'd8, d); chk("R6 its header", d, 32'hA0);
    wr(4'd0, 32'h200);
    rd(4'd7, d); chk("R7 other clear keeps pointer", d, 32'd2);
    wr(4'd0, 32'h004);
    rd(4'd7, d); chk("R7 advance 1", d, 32'd6);
    rd(4'd9, d); chk("R7 header follows", d, 32'hB1);
    wr(4'd0, 32'h040);
    rd(4'd7, d); chk("R7 advance 2", d, 32'd10);
    rd(4'd10, d); chk("R7 header follows 2", d, 32'hC2);
    wr(4'd0, 32'h400);
    rd(4'd7, d); chk("R7 drained", d, 32'd0);
  endtask

  task automatic t_ovf();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hF);
    evt(12'h001, 6'd0, 1'b0, mk_hdr(32'h10));
    evt(12'h002, 6'd0, 1'b0, mk_hdr(32'h20));
    evt(12'h004, 6'd0, 1'b0, mk_hdr(32'h30));
    rd(4'd3, d); chk("R8 no ovf yet", d, 32'h0);
    evt(12'h008, 6'd0, 1'b0, mk_hdr(32'h40));
    chk_msg("R8 nf still wins", 1'b1, 2'd2);
    rd(4'd3, d); chk("R8 ovf bit4", d, 32'h10);
    rd(4'd6, d); chk("R8 ovf counts as cor", d, 32'h3);
    wr(4'd0, 32'h001);
    wr(4'd0, 32'h002);
    rd(4'd8, d); chk("R8 third entry", d, 32'h30);
    wr(4'd0, 32'h004);
    rd(4'd7, d); chk("R8 dropped header", d, 32'd0);
    rd(4'd0, d); chk("R8 status kept", d, 32'h008);
  endtask

  task automatic t_single();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hE);
    evt(12'h010, 6'd0, 1'b0, mk_hdr(32'h50));
    evt(12'h100, 6'd0, 1'b0, mk_hdr(32'h60));
    rd(4'd7, d); chk("R9 first held", d, 32'd4);
    rd(4'd8, d); chk("R9 first header", d, 32'h50);
    rd(4'd3, d); chk("R9 no overflow", d, 32'h0);
    wr(4'd0, 32'h010);
    rd(4'd7, d); chk("R9 second not logged", d, 32'd0);
  endtask

  task automatic t_adv();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hF);
    evt(12'h002, 6'd0, 1'b1, mk_hdr(32'h70));
    chk_msg("R10 advisory as cor", 1'b1, 2'd1);
    rd(4'd3, d); chk("R10 adv bit5", d, 32'h20);
    rd(4'd0, d); chk("R10 ue status", d, 32'h002);
    wr(4'd2, 32'h800);
    evt(12'h800, 6'd0, 1'b1, mk_hdr(32'h80));
    chk_msg("R10 fatal unaffected", 1'b1, 2'd3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_sev();
    t_mask();
    t_ce();
    t_enable();
    t_prio();
    t_order();
    t_ovf();
    t_single();
    t_adv();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule